// File: doc/BRIEF.md
# Seconds Watchdog With Reset Pulse

This block is a countdown watchdog that lives as logical device 8 inside a byte-wide configuration register bank. Software first writes the device number into the device-select register, then sets the activate bit, and finally writes a nonzero number of seconds into the count register. From then on the count drops by one on every one-second tick. The tick comes from an internal prescaler of `TICK_CLKS` clocks. The count register holds both the load value and the live count, so reading it gives the time left. Writing zero stops the timer.

If the count reaches zero, the block sets a sticky expiry flag and drives the active-low watchdog output low for `PULSE_CLKS` clocks. When enabled, it drives the keyboard-reset line low for the same pulse. Software can arm keyboard or mouse activity to cancel a running countdown, and it can stretch each count step to a minute of `MIN_SECS` ticks.

Top module: `wdog_sec_top`

## Requirements
- R1: After reset every register reads 0x00, and `wdt_out_n` and `kbrst_n` are both high.
- R2: Register 0x07 (device select) can always be read and written. Registers 0x30, 0xF5, 0xF6 and 0xF7 are reachable only while 0x07 holds 0x08. Otherwise they read 0x00 and writes to them are ignored.
- R3: While 0x30 bit 0 is set and register 0xF6 is nonzero, 0xF6 drops by one every `TICK_CLKS` clocks. The first drop comes `TICK_CLKS` clocks after the edge that loaded the count or set the activate bit. Reading 0xF6 returns the seconds left.
- R4: Writing 0x00 to 0xF6 stops the timer. The count stays 0 and no pulse is produced.
- R5: Writing 0xF6 while counting reloads the count and restarts the one-second phase.
- R6: While 0x30 bit 0 is clear, the count holds its value and never expires.
- R7: On the step from 1 to 0, bit 4 of 0xF7 sets and `wdt_out_n` is low for exactly `PULSE_CLKS` clocks, starting the cycle after that step. The count then stays 0.
- R8: With 0xF5 bit 1 set, `kbrst_n` pulses low together with `wdt_out_n`. With bit 1 clear, `kbrst_n` stays high.
- R9: With 0xF5 bit 3 set, each count step lasts `MIN_SECS` seconds instead of one.
- R10: A `kbd_evt` cycle clears a running count to 0 without an expiry when 0xF7 bit 6 or 0xF5 bit 2 is set. With both bits clear, the event has no effect.
- R11: A `mouse_evt` cycle clears a running count to 0 when 0xF7 bit 7 is set. With bit 7 clear, the event has no effect.
- R12: Writing 0 to 0xF7 bit 4 clears the expiry flag, and writing 1 to it does not set it. The other bits of 0xF7, and every bit of 0x30 and 0xF5, read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register index for read and write |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| kbd_evt | input | 1 | Keyboard activity, one cycle per event |
| mouse_evt | input | 1 | Mouse activity, one cycle per event |
| wdt_out_n | output | 1 | Active-low watchdog expiry pulse |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
The bench samples the count in the cycle just before each step and in the cycle of the step. A prescaler that is off by one therefore shows the wrong value at the boundary. A reload in the middle of a second must restart the phase; a design that kept the old phase would decrement early. The test also counts the pulse width exactly, checks that the expiry flag cannot be set by software, and covers the cases where cancel and device-select gating must do nothing: a design that let the events through or that decoded unselected writes would corrupt the count.

// File: rtl/wdog_sec_pkg.sv
package wdog_sec_pkg;

  localparam logic [7:0] A_DEVSEL = 8'h07;
  localparam logic [7:0] A_ACT    = 8'h30;
  localparam logic [7:0] A_CTL    = 8'hF5;
  localparam logic [7:0] A_CNT    = 8'hF6;
  localparam logic [7:0] A_CSR    = 8'hF7;

  localparam int B_ACT_ON    = 0;
  localparam int B_CTL_KBRST = 1;
  localparam int B_CTL_KBDCN = 2;
  localparam int B_CTL_MIN   = 3;
  localparam int B_CSR_FIRED = 4;
  localparam int B_CSR_KBDCN = 6;
  localparam int B_CSR_MSECN = 7;

  typedef struct packed {
    logic act;
    logic kbrst_en;
    logic min_unit;
    logic kbd_cancel;
    logic mouse_cancel;
  } wdog_cfg_t;

  // Next value of the count register; load beats cancel beats step.
  function automatic logic [7:0] f_next_count(input logic [7:0] cur,
                                              input logic       load,
                                              input logic [7:0] ld_val,
                                              input logic       cancel,
                                              input logic       step);
    if (load)                  return ld_val;
    if (cancel)                return 8'd0;
    if (step && cur != 8'd0)   return cur - 8'd1;
    return cur;
  endfunction

  // Expiry happens only on a true step from 1 to 0.
  function automatic logic f_expires(input logic [7:0] cur,
                                     input logic       load,
                                     input logic       cancel,
                                     input logic       step);
    return step && !load && !cancel && (cur == 8'd1);
  endfunction

  // Status byte with the sticky expiry flag merged into its bit.
  function automatic logic [7:0] f_csr_view(input logic [7:0] stored,
                                            input logic       fired);
    logic [7:0] v;
    v = stored;
    v[B_CSR_FIRED] = fired;
    return v;
  endfunction

endpackage

// File: rtl/wdog_regbank.sv
module wdog_regbank
  import wdog_sec_pkg::*;
#(
  parameter logic [7:0] DEV_NUM = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic [7:0] count_q,
  input  logic       fired_q,
  output wdog_cfg_t  cfg,
  output logic       cnt_wr,
  output logic [7:0] cnt_wdata,
  output logic       fired_clr,
  output logic [7:0] rdata
);

  logic [7:0] devsel_q;
  logic [7:0] act_q;
  logic [7:0] ctl_q;
  logic [7:0] csr_q;
  logic       dev_hit;
  logic       wr_dev;

  assign dev_hit   = (devsel_q == DEV_NUM);
  assign wr_dev    = wr && dev_hit;
  assign cnt_wr    = wr_dev && (addr == A_CNT);
  assign cnt_wdata = wdata;
  assign fired_clr = wr_dev && (addr == A_CSR) && !wdata[B_CSR_FIRED];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devsel_q <= 8'd0;
      act_q    <= 8'd0;
      ctl_q    <= 8'd0;
      csr_q    <= 8'd0;
    end else if (wr) begin
      if (addr == A_DEVSEL) devsel_q <= wdata;
      if (wr_dev && addr == A_ACT) act_q <= wdata;
      if (wr_dev && addr == A_CTL) ctl_q <= wdata;
      if (wr_dev && addr == A_CSR) begin
        csr_q <= wdata;
        csr_q[B_CSR_FIRED] <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg.act          = act_q[B_ACT_ON];
    cfg.kbrst_en     = ctl_q[B_CTL_KBRST];
    cfg.min_unit     = ctl_q[B_CTL_MIN];
    cfg.kbd_cancel   = ctl_q[B_CTL_KBDCN] | csr_q[B_CSR_KBDCN];
    cfg.mouse_cancel = csr_q[B_CSR_MSECN];
  end

  always_comb begin
    rdata = 8'd0;
    if (addr == A_DEVSEL) begin
      rdata = devsel_q;
    end else if (dev_hit) begin
      case (addr)
        A_ACT:   rdata = act_q;
        A_CTL:   rdata = ctl_q;
        A_CNT:   rdata = count_q;
        A_CSR:   rdata = f_csr_view(csr_q, fired_q);
        default: rdata = 8'd0;
      endcase
    end
  end

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int TICK_CLKS = 50_000_000,
  parameter int MIN_SECS  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic min_unit,
  output logic step
);

  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam int SW = (MIN_SECS > 1) ? $clog2(MIN_SECS) : 1;

  logic [PW-1:0] pre_q;
  logic [SW-1:0] sec_q;
  logic          sec_tick;
  logic          last_sec;

  assign sec_tick = run && (pre_q == PW'(TICK_CLKS - 1));
  assign last_sec = (sec_q == SW'(MIN_SECS - 1));
  assign step     = sec_tick && (!min_unit || last_sec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sec_q <= '0;
    end else if (restart || !run) begin
      pre_q <= '0;
      sec_q <= '0;
    end else begin
      pre_q <= sec_tick ? '0 : pre_q + PW'(1);
      if (sec_tick && min_unit) sec_q <= last_sec ? '0 : sec_q + SW'(1);
    end
  end

endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_sec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] ld_val,
  input  logic       cancel,
  input  logic       step,
  input  logic       fired_clr,
  output logic [7:0] count_q,
  output logic       fired_q,
  output logic       expire
);

  assign expire = f_expires(count_q, load, cancel, step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= 8'd0;
      fired_q <= 1'b0;
    end else begin
      count_q <= f_next_count(count_q, load, ld_val, cancel, step);
      if (expire)         fired_q <= 1'b1;
      else if (fired_clr) fired_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_CLKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pin_n
);

  localparam int CW = $clog2(PULSE_CLKS + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= CW'(PULSE_CLKS);
    else if (left_q != '0)   left_q <= left_q - CW'(1);
  end

  assign pin_n = (left_q == '0);

endmodule

// File: rtl/wdog_sec_top.sv
module wdog_sec_top
  import wdog_sec_pkg::*;
#(
  parameter int         TICK_CLKS  = 50_000_000,
  parameter int         MIN_SECS   = 60,
  parameter int         PULSE_CLKS = 16,
  parameter logic [7:0] DEV_NUM    = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  output logic [7:0] reg_rdata,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  output logic       wdt_out_n,
  output logic       kbrst_n
);

  localparam int NPIN = 2;

  wdog_cfg_t  cfg;
  logic       cnt_wr;
  logic [7:0] cnt_wdata;
  logic       fired_clr;
  logic [7:0] count_q;
  logic       fired_q;
  logic       expire_w;
  logic       step_w;
  logic       run_w;
  logic       cancel_w;
  logic       act_w;
  logic [NPIN-1:0] fire_v;
  logic [NPIN-1:0] pin_v;

  assign act_w    = cfg.act;
  assign run_w    = cfg.act && (count_q != 8'd0);
  assign cancel_w = run_w && ((kbd_evt && cfg.kbd_cancel) ||
                              (mouse_evt && cfg.mouse_cancel));

  wdog_regbank #(.DEV_NUM(DEV_NUM)) i_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .wr(reg_wr),
    .count_q(count_q), .fired_q(fired_q), .cfg(cfg), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .fired_clr(fired_clr), .rdata(reg_rdata)
  );

  wdog_timebase #(.TICK_CLKS(TICK_CLKS), .MIN_SECS(MIN_SECS)) i_tbase (
    .clk(clk), .rst_n(rst_n), .run(run_w), .restart(cnt_wr),
    .min_unit(cfg.min_unit), .step(step_w)
  );

  wdog_count i_count (
    .clk(clk), .rst_n(rst_n), .load(cnt_wr), .ld_val(cnt_wdata),
    .cancel(cancel_w), .step(step_w), .fired_clr(fired_clr),
    .count_q(count_q), .fired_q(fired_q), .expire(expire_w)
  );

  assign fire_v = {expire_w && cfg.kbrst_en, expire_w};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    wdog_pulse #(.PULSE_CLKS(PULSE_CLKS)) i_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire_v[g]), .pin_n(pin_v[g])
    );
  end

  assign wdt_out_n = pin_v[0];
  assign kbrst_n   = pin_v[1];

endmodule

// File: rtl/wdog_sec_chk.sv
module wdog_sec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       act,
  input logic       cnt_wr,
  input logic       cancel,
  input logic       expire,
  input logic       fired,
  input logic       fired_clr,
  input logic [7:0] count,
  input logic       wdt_out_n,
  input logic       kbrst_n
);

  assert_expire_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!wdt_out_n && count == 8'd0 && fired));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !cnt_wr) |=> $stable(count));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count == $past(count) || count == $past(count) - 8'd1 || count == 8'd0));

  assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !cnt_wr) |=> (count == 8'd0));

  assert_kbrst_with_wdt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !kbrst_n |-> !wdt_out_n);

  assert_fired_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !fired_clr) |=> fired);

endmodule

bind wdog_sec_top wdog_sec_chk i_chk (
  .clk(clk), .rst_n(rst_n), .act(act_w), .cnt_wr(cnt_wr), .cancel(cancel_w),
  .expire(expire_w), .fired(fired_q), .fired_clr(fired_clr), .count(count_q),
  .wdt_out_n(wdt_out_n), .kbrst_n(kbrst_n)
);

// File: tb/test_wdog_sec_top.sv
module test_wdog_sec_top;

  localparam int T = 4;
  localparam int M = 3;
  localparam int P = 5;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic       kbd_evt = 1'b0;
  logic       mouse_evt = 1'b0;
  logic       wdt_out_n;
  logic       kbrst_n;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t q[$];
  event  smp_ev;

  always #10 clk = ~clk;

  wdog_sec_top #(.TICK_CLKS(T), .MIN_SECS(M), .PULSE_CLKS(P)) i_wdog_sec_top (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .kbd_evt(kbd_evt),
    .mouse_evt(mouse_evt), .wdt_out_n(wdt_out_n), .kbrst_n(kbrst_n)
  );

  // Monitor: pops expected items and compares them with the ports.
  always begin
    @(smp_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act_v;
      it = q.pop_front();
      case (it.kind)
        0:       act_v = reg_rdata;
        1:       act_v = {7'd0, wdt_out_n};
        default: act_v = {7'd0, kbrst_n};
      endcase
      checks++;
      if (act_v !== it.exp) begin
        errors++;
        $display("FAIL %s actual %0h expected %0h", it.req, act_v, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    #1;
    q.push_back(it);
    -> smp_ev;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    push(0, exp, req);
  endtask

  task automatic pin_wdt(input logic v, input string req);
    push(1, {7'd0, v}, req);
  endtask

  task automatic pin_kb(input logic v, input string req);
    push(2, {7'd0, v}, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kbd();
    kbd_evt = 1'b1;
    @(negedge clk);
    kbd_evt = 1'b0;
  endtask

  task automatic mouse();
    mouse_evt = 1'b1;
    @(negedge clk);
    mouse_evt = 1'b0;
  endtask

  initial begin
    skip(3);
    rst_n = 1'b1;
    skip(1);
    // R1 reset state
    rd(8'h07, 8'h00, "R1 devsel");
    rd(8'hF6, 8'h00, "R1 count");
    pin_wdt(1'b1, "R1 wdt_out_n");
    pin_kb(1'b1, "R1 kbrst_n");
    // R2 writes ignored while another device is selected
    wr(8'hF6, 8'd5);
    wr(8'h30, 8'h01);
    wr(8'h07, 8'h08);
    rd(8'h07, 8'h08, "R2 devsel readback");
    rd(8'hF6, 8'h00, "R2 count write ignored");
    rd(8'h30, 8'h00, "R2 activate write ignored");
    // R6 frozen while not activated
    wr(8'hF6, 8'd3);
    skip(20);
    rd(8'hF6, 8'd3, "R6 frozen count");
    pin_wdt(1'b1, "R6 no pulse");
    // R3 countdown after activation
    wr(8'h30, 8'h01);
    skip(T - 1);
    rd(8'hF6, 8'd3, "R3 before first step");
    skip(1);
    rd(8'hF6, 8'd2, "R3 first step");
    skip(T);
    rd(8'hF6, 8'd1, "R3 second step");
    // R4 stop
    wr(8'hF6, 8'd0);
    rd(8'hF6, 8'd0, "R4 stopped");
    skip(3 * T);
    rd(8'hF6, 8'd0, "R4 stays zero");
    pin_wdt(1'b1, "R4 no pulse");
    rd(8'hF7, 8'h00, "R4 no expiry flag");
    // R5 reload restarts the phase
    wr(8'hF6, 8'd3);
    skip(T + 1);
    rd(8'hF6, 8'd2, "R5 before reload");
    wr(8'hF6, 8'd3);
    rd(8'hF6, 8'd3, "R5 reloaded");
    skip(T - 1);
    rd(8'hF6, 8'd3, "R5 phase restarted");
    skip(1);
    rd(8'hF6, 8'd2, "R5 step after reload");
    // R7 expiry
    wr(8'hF6, 8'd2);
    skip(2 * T - 1);
    rd(8'hF6, 8'd1, "R7 last second");
    pin_wdt(1'b1, "R7 before expiry");
    skip(1);
    rd(8'hF6, 8'd0, "R7 count zero");
    pin_wdt(1'b0, "R7 pulse start");
    pin_kb(1'b1, "R8 kbrst idle when disabled");
    rd(8'hF7, 8'h10, "R7 expiry flag");
    skip(P - 1);
    pin_wdt(1'b0, "R7 pulse last cycle");
    skip(1);
    pin_wdt(1'b1, "R7 pulse end");
    skip(10);
    rd(8'hF6, 8'd0, "R7 count holds zero");
    // R12 expiry flag handling
    wr(8'hF7, 8'hD0);
    rd(8'hF7, 8'hD0, "R12 flag kept on write 1");
    wr(8'hF7, 8'hC0);
    rd(8'hF7, 8'hC0, "R12 flag cleared");
    wr(8'hF7, 8'h10);
    rd(8'hF7, 8'h00, "R12 flag not set by write");
    wr(8'h30, 8'h01);
    rd(8'h30, 8'h01, "R12 activate readback");
    // R8 keyboard-reset pulse
    wr(8'hF5, 8'h02);
    rd(8'hF5, 8'h02, "R12 control readback");
    wr(8'hF6, 8'd1);
    skip(T - 1);
    pin_kb(1'b1, "R8 before expiry");
    skip(1);
    pin_wdt(1'b0, "R8 wdt pulse");
    pin_kb(1'b0, "R8 kbrst pulse");
    skip(P);
    pin_wdt(1'b1, "R8 wdt end");
    pin_kb(1'b1, "R8 kbrst end");
    wr(8'hF5, 8'h00);
    wr(8'hF7, 8'h00);
    // R9 minute unit
    wr(8'hF5, 8'h08);
    wr(8'hF6, 8'd1);
    skip(T * M - 1);
    rd(8'hF6, 8'd1, "R9 long step pending");
    skip(1);
    rd(8'hF6, 8'd0, "R9 long step done");
    pin_wdt(1'b0, "R9 expiry pulse");
    wr(8'hF5, 8'h00);
    wr(8'hF7, 8'h00);
    skip(P);
    // R10 keyboard cancel
    wr(8'hF7, 8'h40);
    wr(8'hF6, 8'd5);
    skip(2);
    kbd();
    rd(8'hF6, 8'd0, "R10 cancel via status bit");
    skip(6 * T);
    rd(8'hF6, 8'd0, "R10 stays cancelled");
    pin_wdt(1'b1, "R10 no pulse");
    rd(8'hF7, 8'h40, "R10 no expiry flag");
    wr(8'hF7, 8'h00);
    wr(8'hF5, 8'h04);
    wr(8'hF6, 8'd5);
    kbd();
    rd(8'hF6, 8'd0, "R10 cancel via control bit");
    wr(8'hF5, 8'h00);
    wr(8'hF6, 8'd5);
    kbd();
    mouse();
    rd(8'hF6, 8'd5, "R10 R11 events ignored when disabled");
    // R11 mouse cancel
    wr(8'hF7, 8'h80);
    wr(8'hF6, 8'd5);
    mouse();
    rd(8'hF6, 8'd0, "R11 mouse cancel");
    skip(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before end of test");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule